// File: doc/BRIEF.md
# Ethernet Controller Command and Interrupt Register Bank

This block is the host-facing register bank of a DMA-driven Ethernet controller. The host reaches it through a 16-bit read/write port addressed by a 6-bit register index. Reads are combinational. Writes take effect at the next rising clock edge. The bank turns writes to the command register into one-cycle action strobes for the engines around it: transmit, receiver on and off, timer run and halt, software reset, receive-resource fetch and address-table load.

Command bits stay set until the engine serving them reports completion. Mutually exclusive commands cancel each other. A software reset state gates writes to the configuration registers. The bank also holds the interrupt mask and interrupt status registers and drives one level-sensitive interrupt line. The engines set status bits through a pulse vector.

Each of the remaining registers follows its own write rule. The rules are write-one-to-clear, writes accepted only in reset, host-writable high fields, forced word alignment, inverted storage and read-only. All other registers are plain storage. The DMA and packet engines themselves are outside this block.

Top module: `nic_ctrl_regs`

## Requirements
- R1: After the synchronous reset, reads return the following values: command (index 0x00) 0x0094; receive control (0x02) 0x0020; transmit control (0x03) 0x0101; buffer-end count (0x13) 0x02F8; revision (0x28) 0x0004. Every other index, including mask (0x04), status (0x05) and address-table enable (0x25), reads 0.
- R2: While command bit 7 (software reset) is set, a command write with bit 7 clear only clears bit 7. It changes no other command bit and issues no strobe.
- R3: Otherwise, a command write ORs the data ANDed with 0x03BF into the register. Each written command bit issues its strobe for exactly the one cycle after the write. The command bits are: bit0 halt-transmit (no strobe), bit1 transmit, bit2 receiver-off, bit3 receiver-on, bit4 timer-halt, bit5 timer-run, bit7 software reset, bit8 resource fetch, bit9 table load.
- R4: Writing bit3 clears bit2, and writing bit2 clears bit3. Writing bit5 clears bit4, and writing bit4 clears bit5. When both bits of a pair are written together, both end up clear.
- R5: A command write with bit7 set clears bits 9, 8, 1 and 0 and sets bits 7 and 2, after the cancellations of R4. It suppresses the transmit, resource-fetch and table-load strobes of that same write.
- R6: A pulse on `eng_tx_done`, `eng_rra_done` or `eng_cam_done` clears command bit 1, 8 or 9 respectively.
- R7: Writing the status register (0x05) clears exactly those set bits where the data has a 1. Bits of `eng_stat_set` set status bits, and a set wins over a clear in the same cycle.
- R8: The mask register (0x04) stores data ANDed with 0x7FFF. `irq` is high exactly when mask AND status is nonzero.
- R9: A status write that clears a set bit 5 issues the resource-fetch strobe in the next cycle.
- R10: Data configuration (0x01, data ANDed with 0xBFFF) and secondary configuration (0x3F, data ANDed with 0xF017) accept writes only while command bit 7 is set. Otherwise the write leaves them unchanged.
- R11: Transmit control (0x03) writes replace bits 15:12 and keep bits 11:0. Receive control (0x02) writes replace bits 15:5 and keep bits 4:0.
- R12: Ring-pointer registers 0x15 to 0x18 store the data with bit0 forced to 0. Tally registers 0x2C to 0x2E store the bitwise inverse of the data. Indices 0x22 to 0x24, 0x28 and 0x2F ignore writes. Every other index stores the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write enable |
| host_addr | input | 6 | Register index |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for `host_addr` |
| eng_tx_done | input | 1 | Transmit engine finished |
| eng_rra_done | input | 1 | Resource fetch finished |
| eng_cam_done | input | 1 | Address-table load finished |
| eng_stat_set | input | 16 | Status set pulses |
| irq | output | 1 | Interrupt level |
| act_tx | output | 1 | Transmit strobe |
| act_rx_on | output | 1 | Receiver-on strobe |
| act_rx_off | output | 1 | Receiver-off strobe |
| act_tmr_run | output | 1 | Timer-run strobe |
| act_tmr_halt | output | 1 | Timer-halt strobe |
| act_sw_reset | output | 1 | Software reset strobe |
| act_rra_fetch | output | 1 | Resource-fetch strobe |
| act_cam_load | output | 1 | Table-load strobe |

## Verification
The bench targets the following corner cases, and each one catches a specific wrong design:
- **Reset-exit write.** A design that also ORs in the other bits of this write would leave stray commands latched and issue their strobes.
- **Every single command bit and every combination of the two cancelling pairs.** This catches a design that fails to clear the opposite bit, or that applies the cancellations in the wrong order.
- **A full sweep of all 64 indices, both in and out of reset.** This exposes any register with the wrong mask, inversion, alignment or reset gate as a value that differs from the one the bench computes.
- **A status clear that coincides with a set pulse, and a mask-by-status sweep of the interrupt line.** These would show a lost event, or an interrupt raised through bit 15 of the mask.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    localparam int REG_AW  = 6;
    localparam int REG_DW  = 16;
    localparam int REG_CNT = 1 << REG_AW;

    typedef logic [REG_DW-1:0] word_t;
    typedef logic [REG_AW-1:0] ridx_t;

    // register indices the host software decodes
    localparam ridx_t IX_CMD      = 6'h00;
    localparam ridx_t IX_DCFG     = 6'h01;
    localparam ridx_t IX_RXC      = 6'h02;
    localparam ridx_t IX_TXC      = 6'h03;
    localparam ridx_t IX_IMASK    = 6'h04;
    localparam ridx_t IX_ISTAT    = 6'h05;
    localparam ridx_t IX_EOBC     = 6'h13;
    localparam ridx_t IX_RING_LO  = 6'h15;
    localparam ridx_t IX_RING_HI  = 6'h18;
    localparam ridx_t IX_CAMP_LO  = 6'h22;
    localparam ridx_t IX_CAMP_HI  = 6'h24;
    localparam ridx_t IX_REV      = 6'h28;
    localparam ridx_t IX_TALLY_LO = 6'h2C;
    localparam ridx_t IX_TALLY_HI = 6'h2E;
    localparam ridx_t IX_MDT      = 6'h2F;
    localparam ridx_t IX_DCFG2    = 6'h3F;

    // command bit positions
    localparam int CB_HALT  = 0;
    localparam int CB_TX    = 1;
    localparam int CB_RXOFF = 2;
    localparam int CB_RXON  = 3;
    localparam int CB_TSTOP = 4;
    localparam int CB_TRUN  = 5;
    localparam int CB_SRST  = 7;
    localparam int CB_RRA   = 8;
    localparam int CB_CAM   = 9;

    localparam int ST_RBE = 5;

    localparam word_t CMD_WMASK   = 16'h03BF;
    localparam word_t CMD_RST_VAL = 16'h0094;
    localparam word_t IMASK_WMASK = 16'h7FFF;
    localparam word_t DCFG_WMASK  = 16'hBFFF;
    localparam word_t DCFG2_WMASK = 16'hF017;
    localparam word_t TXC_HOST    = 16'hF000;
    localparam word_t RXC_HOST    = 16'hFFE0;
    localparam word_t ALIGN_WMASK = 16'hFFFE;
    localparam word_t TXC_RST_VAL = 16'h0101;
    localparam word_t RXC_RST_VAL = 16'h0020;
    localparam word_t EOBC_RST    = 16'h02F8;

    typedef enum logic [2:0] {
        RK_PLAIN, RK_DROP, RK_CFG, RK_CFG2, RK_RXC, RK_TXC, RK_ALIGN, RK_INVERT
    } rule_kind_t;

    typedef struct packed {
        logic  accept;
        word_t value;
    } wr_result_t;

    typedef struct packed {
        logic tx;
        logic rx_on;
        logic rx_off;
        logic tmr_run;
        logic tmr_halt;
        logic sw_reset;
        logic rra;
        logic cam;
    } act_t;

    function automatic rule_kind_t reg_kind(ridx_t ix);
        rule_kind_t k;
        k = RK_PLAIN;
        if (ix == IX_CMD || ix == IX_IMASK || ix == IX_ISTAT) k = RK_DROP;
        else if ((ix >= IX_CAMP_LO && ix <= IX_CAMP_HI) || ix == IX_REV || ix == IX_MDT) k = RK_DROP;
        else if (ix == IX_DCFG) k = RK_CFG;
        else if (ix == IX_DCFG2) k = RK_CFG2;
        else if (ix == IX_RXC) k = RK_RXC;
        else if (ix == IX_TXC) k = RK_TXC;
        else if (ix >= IX_RING_LO && ix <= IX_RING_HI) k = RK_ALIGN;
        else if (ix >= IX_TALLY_LO && ix <= IX_TALLY_HI) k = RK_INVERT;
        return k;
    endfunction

    function automatic word_t reg_reset_value(ridx_t ix, word_t rev);
        word_t v;
        case (ix)
            IX_RXC:  v = RXC_RST_VAL;
            IX_TXC:  v = TXC_RST_VAL;
            IX_EOBC: v = EOBC_RST;
            IX_REV:  v = rev;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic wr_result_t reg_write_rule(ridx_t ix, word_t old, word_t wd, logic in_reset);
        wr_result_t r;
        r.accept = 1'b1;
        r.value  = wd;
        case (reg_kind(ix))
            RK_DROP:   r.accept = 1'b0;
            RK_CFG:    begin r.accept = in_reset; r.value = wd & DCFG_WMASK;  end
            RK_CFG2:   begin r.accept = in_reset; r.value = wd & DCFG2_WMASK; end
            RK_RXC:    r.value = (wd & RXC_HOST) | (old & ~RXC_HOST);
            RK_TXC:    r.value = (wd & TXC_HOST) | (old & ~TXC_HOST);
            RK_ALIGN:  r.value = wd & ALIGN_WMASK;
            RK_INVERT: r.value = ~wd;
            default:   r.value = wd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nic_cmd_unit.sv
module nic_cmd_unit
    import nic_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wd,
    input  logic  tx_done,
    input  logic  rra_done,
    input  logic  cam_done,
    input  logic  rra_kick,
    output word_t cmd_q,
    output act_t  act_q
);
    localparam word_t SRST_BIT = word_t'(1) << CB_SRST;

    word_t cmd_d;
    act_t  act_d;

    always_comb begin
        cmd_d = cmd_q;
        act_d = '0;
        if (tx_done)  cmd_d[CB_TX]  = 1'b0;
        if (rra_done) cmd_d[CB_RRA] = 1'b0;
        if (cam_done) cmd_d[CB_CAM] = 1'b0;
        if (wr_en) begin
            if (cmd_q[CB_SRST] && !wd[CB_SRST]) begin
                cmd_d[CB_SRST] = 1'b0;
            end else begin
                cmd_d = cmd_d | (wd & CMD_WMASK);
                if (wd[CB_RXOFF]) cmd_d[CB_RXON]  = 1'b0;
                if (wd[CB_RXON])  cmd_d[CB_RXOFF] = 1'b0;
                if (wd[CB_TSTOP]) cmd_d[CB_TRUN]  = 1'b0;
                if (wd[CB_TRUN])  cmd_d[CB_TSTOP] = 1'b0;
                act_d.tx       = wd[CB_TX];
                act_d.rx_off   = wd[CB_RXOFF];
                act_d.rx_on    = wd[CB_RXON];
                act_d.tmr_halt = wd[CB_TSTOP];
                act_d.tmr_run  = wd[CB_TRUN];
                act_d.rra      = wd[CB_RRA];
                act_d.cam      = wd[CB_CAM];
                if (wd[CB_SRST]) begin
                    cmd_d[CB_CAM]   = 1'b0;
                    cmd_d[CB_RRA]   = 1'b0;
                    cmd_d[CB_TX]    = 1'b0;
                    cmd_d[CB_HALT]  = 1'b0;
                    cmd_d[CB_SRST]  = 1'b1;
                    cmd_d[CB_RXOFF] = 1'b1;
                    act_d.sw_reset  = 1'b1;
                    act_d.tx        = 1'b0;
                    act_d.rra       = 1'b0;
                    act_d.cam       = 1'b0;
                end
            end
        end
        if (rra_kick) act_d.rra = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_RST_VAL;
            act_q <= '0;
        end else begin
            cmd_q <= cmd_d;
            act_q <= act_d;
        end
    end

    // R2
    rst_exit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && cmd_q[CB_SRST] && !wd[CB_SRST] && !tx_done && !rra_done && !cam_done
        |=> cmd_q == ($past(cmd_q) & ~SRST_BIT));

    // R3
    cam_src_chk: assert property (@(posedge clk) disable iff (rst)
        act_q.cam |-> $past(wr_en && wd[CB_CAM]));

    // R3
    rxon_src_chk: assert property (@(posedge clk) disable iff (rst)
        act_q.rx_on |-> $past(wr_en && wd[CB_RXON]));

    // R5
    srst_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wd[CB_SRST]
        |=> cmd_q[CB_SRST] && cmd_q[CB_RXOFF] && !cmd_q[CB_TX] && !act_q.tx && !act_q.cam);

    // R6
    txdone_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done && !(wr_en && wd[CB_TX]) |=> !cmd_q[CB_TX]);

endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
    import nic_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mask_wr,
    input  logic  stat_wr,
    input  word_t wd,
    input  word_t stat_set,
    output word_t imask_q,
    output word_t istat_q,
    output logic  rra_kick,
    output logic  irq
);
    word_t clr;

    assign clr      = stat_wr ? (wd & istat_q) : '0;
    assign rra_kick = clr[ST_RBE];
    assign irq      = |(imask_q & istat_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            imask_q <= '0;
            istat_q <= '0;
        end else begin
            if (mask_wr) imask_q <= wd & IMASK_WMASK;
            istat_q <= (istat_q & ~clr) | stat_set;
        end
    end

    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr && stat_set == '0 |=> (istat_q & $past(wd & istat_q)) == '0);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        stat_set != '0 |=> (istat_q & $past(stat_set)) == $past(stat_set));

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        stat_set == '0 |=> (istat_q & ~$past(istat_q)) == '0);

endmodule

// File: rtl/nic_cfg_bank.sv
module nic_cfg_bank
    import nic_regs_pkg::*;
#(
    parameter word_t REV_ID = 16'h0004
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ridx_t wr_idx,
    input  word_t wr_data,
    input  logic  in_reset,
    input  ridx_t rd_idx,
    output word_t rd_data
);
    word_t view [REG_CNT];

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        localparam ridx_t MY_IX = ridx_t'(g);
        word_t      q;
        wr_result_t res;

        assign res = reg_write_rule(MY_IX, q, wr_data, in_reset);

        always_ff @(posedge clk) begin
            if (rst)
                q <= reg_reset_value(MY_IX, REV_ID);
            else if (wr_en && wr_idx == MY_IX && res.accept)
                q <= res.value;
        end

        assign view[g] = q;
    end

    assign rd_data = view[rd_idx];

    // R10
    dcfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_idx == IX_DCFG && !in_reset |=> $stable(view[IX_DCFG]));

    // R12
    rev_ro_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_idx == IX_REV |=> $stable(view[IX_REV]));

endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
    import nic_regs_pkg::*;
#(
    parameter logic [15:0] REV_ID = 16'h0004
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [5:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    input  logic        eng_tx_done,
    input  logic        eng_rra_done,
    input  logic        eng_cam_done,
    input  logic [15:0] eng_stat_set,
    output logic        irq,
    output logic        act_tx,
    output logic        act_rx_on,
    output logic        act_rx_off,
    output logic        act_tmr_run,
    output logic        act_tmr_halt,
    output logic        act_sw_reset,
    output logic        act_rra_fetch,
    output logic        act_cam_load
);
    word_t cmd_q, imask_q, istat_q, bank_rd;
    act_t  act_q;
    logic  rra_kick;
    logic  sel_cmd, sel_mask, sel_stat;

    assign sel_cmd  = host_wr && host_addr == IX_CMD;
    assign sel_mask = host_wr && host_addr == IX_IMASK;
    assign sel_stat = host_wr && host_addr == IX_ISTAT;

    nic_cmd_unit u_cmd (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sel_cmd),
        .wd       (host_wdata),
        .tx_done  (eng_tx_done),
        .rra_done (eng_rra_done),
        .cam_done (eng_cam_done),
        .rra_kick (rra_kick),
        .cmd_q    (cmd_q),
        .act_q    (act_q)
    );

    nic_irq_unit u_irq (
        .clk      (clk),
        .rst      (rst),
        .mask_wr  (sel_mask),
        .stat_wr  (sel_stat),
        .wd       (host_wdata),
        .stat_set (eng_stat_set),
        .imask_q  (imask_q),
        .istat_q  (istat_q),
        .rra_kick (rra_kick),
        .irq      (irq)
    );

    nic_cfg_bank #(.REV_ID(REV_ID)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr),
        .wr_idx   (host_addr),
        .wr_data  (host_wdata),
        .in_reset (cmd_q[CB_SRST]),
        .rd_idx   (host_addr),
        .rd_data  (bank_rd)
    );

    always_comb begin
        case (host_addr)
            IX_CMD:   host_rdata = cmd_q;
            IX_IMASK: host_rdata = imask_q;
            IX_ISTAT: host_rdata = istat_q;
            default:  host_rdata = bank_rd;
        endcase
    end

    assign act_tx        = act_q.tx;
    assign act_rx_on     = act_q.rx_on;
    assign act_rx_off    = act_q.rx_off;
    assign act_tmr_run   = act_q.tmr_run;
    assign act_tmr_halt  = act_q.tmr_halt;
    assign act_sw_reset  = act_q.sw_reset;
    assign act_rra_fetch = act_q.rra;
    assign act_cam_load  = act_q.cam;

endmodule

// File: tb/sim_nic_ctrl_regs.sv
module sim_nic_ctrl_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        eng_tx_done = 1'b0, eng_rra_done = 1'b0, eng_cam_done = 1'b0;
    logic [15:0] eng_stat_set = '0;
    logic        irq;
    logic        act_tx, act_rx_on, act_rx_off, act_tmr_run, act_tmr_halt;
    logic        act_sw_reset, act_rra_fetch, act_cam_load;

    int n_run = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_ctrl_regs u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_tx_done(eng_tx_done), .eng_rra_done(eng_rra_done), .eng_cam_done(eng_cam_done),
        .eng_stat_set(eng_stat_set), .irq(irq),
        .act_tx(act_tx), .act_rx_on(act_rx_on), .act_rx_off(act_rx_off),
        .act_tmr_run(act_tmr_run), .act_tmr_halt(act_tmr_halt),
        .act_sw_reset(act_sw_reset), .act_rra_fetch(act_rra_fetch), .act_cam_load(act_cam_load)
    );

    // strobe vector order: {load, fetch, swreset, run, halt, rxon, rxoff, tx}
    function automatic logic [7:0] stb_now();
        return {act_cam_load, act_rra_fetch, act_sw_reset, act_tmr_run,
                act_tmr_halt, act_rx_on, act_rx_off, act_tx};
    endfunction

    function automatic logic [15:0] exp_rst(int i);
        case (i)
            'h00: return 16'h0094;
            'h02: return 16'h0020;
            'h03: return 16'h0101;
            'h13: return 16'h02F8;
            'h28: return 16'h0004;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_reg(int i, logic [15:0] old, logic [15:0] d, logic inrst);
        if (i == 'h01) return inrst ? (d & 16'hBFFF) : old;
        if (i == 'h3F) return inrst ? (d & 16'hF017) : old;
        if (i == 'h02) return {d[15:5], old[4:0]};
        if (i == 'h03) return {d[15:12], old[11:0]};
        if (i >= 'h15 && i <= 'h18) return {d[15:1], 1'b0};
        if (i >= 'h2C && i <= 'h2E) return ~d;
        if ((i >= 'h22 && i <= 'h24) || i == 'h28 || i == 'h2F) return old;
        return d;
    endfunction

    function automatic logic [15:0] model_cmd(logic [15:0] old, logic [15:0] d);
        logic [15:0] n;
        if (old[7] && !d[7]) return {old[15:8], 1'b0, old[6:0]};
        n = old | (d & 16'h03BF);
        if (d[2] && d[3]) begin n[2] = 1'b0; n[3] = 1'b0; end
        else if (d[2]) n[3] = 1'b0;
        else if (d[3]) n[2] = 1'b0;
        if (d[4] && d[5]) begin n[4] = 1'b0; n[5] = 1'b0; end
        else if (d[4]) n[5] = 1'b0;
        else if (d[5]) n[4] = 1'b0;
        if (d[7]) begin n[9] = 1'b0; n[8] = 1'b0; n[1] = 1'b0; n[0] = 1'b0; n[2] = 1'b1; end
        return n;
    endfunction

    function automatic logic [7:0] model_stb(logic [15:0] old, logic [15:0] d);
        logic [7:0] s;
        if (old[7] && !d[7]) return 8'h00;
        s = {d[9], d[8], d[7], d[5], d[4], d[3], d[2], d[1]};
        if (d[7]) begin s[7] = 1'b0; s[6] = 1'b0; s[0] = 1'b0; end
        return s;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hard_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_wr(logic [5:0] a, logic [15:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    task automatic rd(logic [5:0] a, output logic [15:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic pulse_set(logic [15:0] s);
        eng_stat_set = s;
        @(negedge clk);
        eng_stat_set = '0;
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [15:0] d;
        logic [15:0] base;
        hard_reset();

        // R1: reset values across every index
        for (int i = 0; i < 64; i++) begin
            rd(6'(i), v);
            check($sformatf("R1 reset idx %0h", i), v, exp_rst(i));
        end
        check("R1 irq low after reset", {15'b0, irq}, 16'h0000);

        // R2: reset-exit write drops everything else
        do_wr(6'h00, 16'h032A);
        check("R2 exit strobes", {8'h00, stb_now()}, 16'h0000);
        rd(6'h00, v);
        check("R2 exit cmd", v, 16'h0014);

        // R3/R5: every single command bit from the running state
        for (int b = 0; b < 16; b++) begin
            hard_reset();
            do_wr(6'h00, 16'h0000);
            d = 16'h1 << b;
            do_wr(6'h00, d);
            check($sformatf("R3 strobe bit %0d", b), {8'h00, stb_now()}, {8'h00, model_stb(16'h0014, d)});
            rd(6'h00, v);
            check($sformatf("R3 cmd bit %0d", b), v, model_cmd(16'h0014, d));
            @(negedge clk); #1;
            check($sformatf("R3 one-cycle bit %0d", b), {8'h00, stb_now()}, 16'h0000);
        end

        // R4: all combinations of the two cancelling pairs, two start states
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 16; c++) begin
                hard_reset();
                do_wr(6'h00, 16'h0000);
                base = 16'h0014;
                if (s == 1) begin
                    do_wr(6'h00, 16'h0028);
                    base = model_cmd(16'h0014, 16'h0028);
                end
                d = 16'(c << 2);
                do_wr(6'h00, d);
                rd(6'h00, v);
                check($sformatf("R4 pair combo %0h start %0d", c, s), v, model_cmd(base, d));
            end
        end

        // R5: reset with every other command bit
        hard_reset();
        do_wr(6'h00, 16'h0000);
        do_wr(6'h00, 16'h0303);
        do_wr(6'h00, 16'hFFFF);
        check("R5 strobes", {8'h00, stb_now()}, {8'h00, model_stb(16'h0317, 16'hFFFF)});
        rd(6'h00, v);
        check("R5 cmd", v, model_cmd(16'h0317, 16'hFFFF));

        // R6: completion inputs
        hard_reset();
        do_wr(6'h00, 16'h0000);
        do_wr(6'h00, 16'h0302);
        rd(6'h00, v);
        check("R6 latched", v, 16'h0316);
        eng_tx_done = 1'b1; @(negedge clk); eng_tx_done = 1'b0;
        rd(6'h00, v);
        check("R6 tx done", v, 16'h0314);
        eng_rra_done = 1'b1; @(negedge clk); eng_rra_done = 1'b0;
        rd(6'h00, v);
        check("R6 rra done", v, 16'h0214);
        eng_cam_done = 1'b1; @(negedge clk); eng_cam_done = 1'b0;
        rd(6'h00, v);
        check("R6 cam done", v, 16'h0014);

        // R7: write-one-to-clear and set-wins
        hard_reset();
        pulse_set(16'hFFFF);
        rd(6'h05, v);
        check("R7 set all", v, 16'hFFFF);
        do_wr(6'h05, 16'h00F0);
        rd(6'h05, v);
        check("R7 clear nibble", v, 16'hFF0F);
        host_addr = 6'h05; host_wdata = 16'hFFFF; host_wr = 1'b1; eng_stat_set = 16'h0003;
        @(negedge clk);
        host_wr = 1'b0; eng_stat_set = '0;
        rd(6'h05, v);
        check("R7 set wins", v, 16'h0003);
        do_wr(6'h05, 16'h0004);
        rd(6'h05, v);
        check("R7 clear of unset bit", v, 16'h0003);

        // R8: mask width and interrupt level sweep
        do_wr(6'h04, 16'hFFFF);
        rd(6'h04, v);
        check("R8 mask bit15 dropped", v, 16'h7FFF);
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                do_wr(6'h04, 16'h1 << i);
                do_wr(6'h05, 16'hFFFF);
                pulse_set(16'h1 << j);
                check($sformatf("R8 irq mask %0d stat %0d", i, j), {15'b0, irq},
                      {15'b0, (i == j) && (i != 15)});
            end
        end

        // R9: clearing buffers-exhausted status triggers fetch strobe
        hard_reset();
        do_wr(6'h05, 16'h0020);
        check("R9 no fetch when bit clear", {15'b0, act_rra_fetch}, 16'h0000);
        pulse_set(16'h0020);
        do_wr(6'h05, 16'h0020);
        check("R9 fetch strobe", {15'b0, act_rra_fetch}, 16'h0001);
        rd(6'h05, v);
        check("R9 status cleared", v, 16'h0000);

        // R10/R11/R12: sweep every bank index in and out of reset
        for (int ph = 0; ph < 2; ph++) begin
            for (int i = 0; i < 64; i++) begin
                if (i == 0 || i == 4 || i == 5) continue;
                d = (ph == 0) ? 16'h5A5B : 16'hA5A5;
                hard_reset();
                if (ph == 1) do_wr(6'h00, 16'h0000);
                do_wr(6'(i), d);
                rd(6'(i), v);
                check($sformatf("R10 R11 R12 idx %0h phase %0d", i, ph), v,
                      exp_reg(i, exp_rst(i), d, ph == 0));
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule